// File: doc/BRIEF.md
# Mode-Selectable Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It runs on one system clock. Two clock-enable strobes stand for the prescaled RF inputs, one for the high band and one for the low band. The block counts strobes from the selected input and emits a one-cycle pulse toward the phase detector each time a full divide cycle completes.

A 16-bit divisor word and two select bits set the division. The high-band select routes the high-band strobe through a fixed divide-by-two stage ahead of the counter. The full-resolution select, which only matters in the low band, decides whether the divisor is the whole word or only its upper twelve bits.

Each mode has a minimum divisor, and smaller values are raised to it. A changed word or mode is picked up only when the current divide cycle ends, so the output never has a short period. While inhibit is high, counting stops. When inhibit is released, the divider starts again from a fresh load.

Top module: `synth_fbdiv`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` is low. The first clock with `rst_n` high and `inhibit` low is a load cycle. A strobe in that cycle is not counted.
- R2: With `sel_high`=0 and `sel_full`=1, the divisor N is `div_word[15:0]`. One pulse is produced per N strobes on `lf_stb`.
- R3: With `sel_high`=0 and `sel_full`=0, N is `div_word[15:4]`, with bit 4 as its least significant bit. Bits 3..0 have no effect on the pulse timing. One pulse is produced per N strobes on `lf_stb`.
- R4: With `sel_high`=1, `sel_full` is ignored and N is `div_word[15:0]`. One pulse is produced per 2·N strobes on `hf_stb`.
- R5: In the two 16-bit modes (R2 and R4), a word below 272 acts as 272.
- R6: In the 12-bit mode (R3), a value below 4 acts as 4.
- R7: Strobes on the input that the active mode does not select have no effect on the count.
- R8: `fb_pulse` is high for exactly one clock. That clock is the one after the edge at which the completing strobe is sampled.
- R9: The word and select bits are sampled only at a load cycle or at the edge that completes a divide cycle. They set the length of the next divide cycle. Changes between those edges do not alter the cycle already in progress.
- R10: While `inhibit` is high, no pulse is produced and strobes are not counted.
- R11: The first clock after `inhibit` falls is a load cycle, as in R1. Counting restarts from zero, with the divide-by-two phase cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hf_stb | input | 1 | High-band prescaled clock-enable strobe |
| lf_stb | input | 1 | Low-band prescaled clock-enable strobe |
| div_word | input | 16 | Divisor word, bit 15 most significant |
| sel_high | input | 1 | 1 selects the high band with the divide-by-two stage |
| sel_full | input | 1 | In the low band: 1 uses the full 16-bit word, 0 uses bits 15..4 |
| inhibit | input | 1 | Stops the divider and blocks pulses while high |
| fb_pulse | output | 1 | One-cycle pulse per completed divide cycle |

## Verification
Suppose the down counter, the divide-by-two phase or the shadowed band bit holds a wrong value. The pulse then lands early or late within that same divide cycle, so the fault shows at the very next expected pulse. That is at most 2·65535 selected strobes away, and only a few hundred with the divisors the bench uses.

A band bit latched at the wrong moment shows up differently. The output either stops responding to the expected strobe input or follows the other one. A missed reload after inhibit moves every later pulse, which a strobe-by-strobe reference model catches on the first pulse after release.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  typedef enum logic [1:0] {
    MODE_NARROW = 2'd0,
    MODE_WIDE   = 2'd1,
    MODE_HIGH   = 2'd2
  } fbdiv_mode_e;

  function automatic fbdiv_mode_e pick_mode(input logic sel_high, input logic sel_full);
    if (sel_high) return MODE_HIGH;
    if (sel_full) return MODE_WIDE;
    return MODE_NARROW;
  endfunction

endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg
  import fbdiv_pkg::*;
#(
  parameter int W          = 16,
  parameter int SHIFT      = 4,
  parameter int MIN_WIDE   = 272,
  parameter int MIN_NARROW = 4
) (
  input  logic [W-1:0] word,
  input  logic         sel_high,
  input  logic         sel_full,
  output logic [W-1:0] count_n,
  output logic         use_high
);

  fbdiv_mode_e mode;

  // move the least significant bit of the divisor according to mode
  function automatic logic [W-1:0] aligned(input logic [W-1:0] w, input fbdiv_mode_e m);
    if (m == MODE_NARROW) return {{SHIFT{1'b0}}, w[W-1:SHIFT]};
    return w;
  endfunction

  function automatic logic [W-1:0] floor_of(input fbdiv_mode_e m);
    if (m == MODE_NARROW) return W'(MIN_NARROW);
    return W'(MIN_WIDE);
  endfunction

  function automatic logic [W-1:0] clamp_up(input logic [W-1:0] v, input logic [W-1:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  always_comb begin
    mode     = pick_mode(sel_high, sel_full);
    count_n  = clamp_up(aligned(word, mode), floor_of(mode));
    use_high = (mode == MODE_HIGH);
  end

endmodule

// File: rtl/fbdiv_prescale.sv
module fbdiv_prescale #(
  parameter bit HIGH_PRE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hf_stb,
  input  logic lf_stb,
  input  logic use_high,
  input  logic clear,
  output logic tick
);

  generate
    if (HIGH_PRE) begin : g_half
      logic phase_q;

      always_ff @(posedge clk) begin
        if (!rst_n)                  phase_q <= 1'b0;
        else if (clear)              phase_q <= 1'b0;
        else if (use_high && hf_stb) phase_q <= ~phase_q;
      end

      assign tick = clear ? 1'b0 : (use_high ? (hf_stb & phase_q) : lf_stb);

      // R4
      half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_high && tick) |=> (!tick || !use_high));
    end else begin : g_direct
      assign tick = clear ? 1'b0 : (use_high ? hf_stb : lf_stb);
    end
  endgenerate

endmodule

// File: rtl/fbdiv_count.sv
module fbdiv_count #(
  parameter int W        = 16,
  parameter int MIN_LOAD = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inhibit,
  input  logic         start,
  input  logic         tick,
  input  logic [W-1:0] load_n,
  output logic         term,
  output logic         pulse
);

  logic [W-1:0] cnt_q;
  logic         pulse_q;

  assign term  = tick & (cnt_q == W'(1));
  assign pulse = pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= term;
      if (start || term) cnt_q <= load_n;
      else if (tick)     cnt_q <= cnt_q - W'(1);
    end
  end

  // R6
  load_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start || term) |=> (cnt_q >= W'(MIN_LOAD)));

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R10
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !pulse_q);

  // R10
  inhibit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> $stable(cnt_q));

endmodule

// File: rtl/synth_fbdiv.sv
module synth_fbdiv
  import fbdiv_pkg::*;
#(
  parameter int W          = 16,
  parameter int SHIFT      = 4,
  parameter int MIN_WIDE   = 272,
  parameter int MIN_NARROW = 4,
  parameter bit HIGH_PRE   = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hf_stb,
  input  logic         lf_stb,
  input  logic [W-1:0] div_word,
  input  logic         sel_high,
  input  logic         sel_full,
  input  logic         inhibit,
  output logic         fb_pulse
);

  logic [W-1:0] next_n;
  logic         next_high;
  logic         need_q;
  logic         band_act_q;
  logic         start;
  logic         term_evt;
  logic         load_evt;
  logic         tick;
  logic         pre_clear;

  fbdiv_cfg #(
    .W(W), .SHIFT(SHIFT), .MIN_WIDE(MIN_WIDE), .MIN_NARROW(MIN_NARROW)
  ) cfg_i (
    .word(div_word), .sel_high(sel_high), .sel_full(sel_full),
    .count_n(next_n), .use_high(next_high)
  );

  assign start     = need_q & ~inhibit;
  assign load_evt  = start | term_evt;
  assign pre_clear = inhibit | need_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       need_q <= 1'b1;
    else if (inhibit) need_q <= 1'b1;
    else              need_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        band_act_q <= 1'b0;
    else if (load_evt) band_act_q <= next_high;
  end

  fbdiv_prescale #(.HIGH_PRE(HIGH_PRE)) pre_i (
    .clk(clk), .rst_n(rst_n), .hf_stb(hf_stb), .lf_stb(lf_stb),
    .use_high(band_act_q), .clear(pre_clear), .tick(tick)
  );

  fbdiv_count #(.W(W), .MIN_LOAD(MIN_NARROW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .start(start),
    .tick(tick), .load_n(next_n), .term(term_evt), .pulse(fb_pulse)
  );

  // R9
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(band_act_q));

  // R11
  release_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inhibit) |-> (start && !tick));

endmodule

// File: tb/synth_fbdiv_tb_top.sv
`timescale 1ns/1ps
module synth_fbdiv_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hf_stb = 1'b0;
  logic        lf_stb = 1'b0;
  logic [15:0] div_word = 16'd0;
  logic        sel_high = 1'b0;
  logic        sel_full = 1'b0;
  logic        inhibit = 1'b0;
  logic        fb_pulse;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  int    npulse = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  int m_need = 1;
  int m_band = 0;
  int m_period = 0;
  int m_seen = 0;

  always #2.5 clk = ~clk;

  synth_fbdiv dut_i (
    .clk(clk), .rst_n(rst_n), .hf_stb(hf_stb), .lf_stb(lf_stb),
    .div_word(div_word), .sel_high(sel_high), .sel_full(sel_full),
    .inhibit(inhibit), .fb_pulse(fb_pulse)
  );

  // selected strobes per output pulse, restated from R2..R6
  function automatic int period_of(input logic [15:0] w, input logic b, input logic f);
    int n;
    if (b || f) begin
      n = int'(w);
      if (n < 272) n = 272;
    end else begin
      n = int'(w) / 16;
      if (n < 4) n = 4;
    end
    return b ? 2 * n : n;
  endfunction

  task automatic check_bit(input bit got, input bit exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: fb_pulse=%0b expected %0b at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string req);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: value=%0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input bit h, input bit l);
    bit exp;
    bit sel;
    @(negedge clk);
    hf_stb = h;
    lf_stb = l;
    @(posedge clk);
    exp = 1'b0;
    if (!rst_n || inhibit) begin
      m_need = 1;
    end else if (m_need != 0) begin
      m_need = 0;
      m_period = period_of(div_word, sel_high, sel_full);
      m_band = int'(sel_high);
      m_seen = 0;
    end else begin
      sel = (m_band != 0) ? h : l;
      if (sel) begin
        m_seen++;
        if (m_seen == m_period) begin
          exp = 1'b1;
          m_seen = 0;
          m_period = period_of(div_word, sel_high, sel_full);
          m_band = int'(sel_high);
        end
      end
    end
    #1;
    cyc++;
    if (exp) npulse++;
    check_bit(fb_pulse, exp, cur_req);
  endtask

  task automatic restart();
    inhibit = 1'b1;
    step(1'b1, 1'b1);
    inhibit = 1'b0;
    step(1'b1, 1'b1);
    npulse = 0;
  endtask

  task automatic run(input int n, input bit h, input bit l);
    for (int i = 0; i < n; i++) step(h, l);
  endtask

  initial begin
    void'($urandom(32'd4711));
    cur_req = "R1";
    run(4, 1'b1, 1'b1);
    rst_n = 1'b1;

    // R2: full 16-bit word, low band
    cur_req = "R2";
    sel_high = 1'b0; sel_full = 1'b1; div_word = 16'd300;
    restart();
    run(650, 1'b1, 1'b1);
    check_int(npulse, 2, "R2");

    // R3: bits 15..4 only, low nibble ignored
    cur_req = "R3";
    sel_full = 1'b0; div_word = 16'h005F;
    restart();
    run(50, 1'b0, 1'b1);
    check_int(npulse, 10, "R3");
    div_word = 16'h0050;
    restart();
    run(50, 1'b0, 1'b1);
    check_int(npulse, 10, "R3");

    // R6: narrow floor
    cur_req = "R6";
    div_word = 16'h0023;
    restart();
    run(40, 1'b0, 1'b1);
    check_int(npulse, 10, "R6");

    // R5: wide floor
    cur_req = "R5";
    sel_full = 1'b1; div_word = 16'd5;
    restart();
    run(544, 1'b0, 1'b1);
    check_int(npulse, 2, "R5");

    // R4: high band, twice the word, sel_full ignored
    cur_req = "R4";
    sel_high = 1'b1; sel_full = 1'b0; div_word = 16'd272;
    restart();
    for (int i = 0; i < 1088; i++) step(1'b1, i[0]);
    check_int(npulse, 2, "R4");

    // R7: unselected input
    cur_req = "R7";
    restart();
    run(600, 1'b0, 1'b1);
    check_int(npulse, 0, "R7");
    sel_high = 1'b0; div_word = 16'h0040;
    restart();
    run(100, 1'b1, 1'b0);
    check_int(npulse, 0, "R7");

    // R8: shortest period, strobe every clock
    cur_req = "R8";
    run(40, 1'b0, 1'b1);
    check_int(npulse, 10, "R8");

    // R9: change mid-cycle takes effect after terminal count
    cur_req = "R9";
    div_word = 16'h0050;
    restart();
    run(2, 1'b0, 1'b1);
    div_word = 16'h0080;
    run(3, 1'b0, 1'b1);
    check_int(npulse, 1, "R9");
    run(7, 1'b0, 1'b1);
    check_int(npulse, 1, "R9");
    run(1, 1'b0, 1'b1);
    check_int(npulse, 2, "R9");

    // R10: inhibit mid-cycle
    cur_req = "R10";
    run(3, 1'b0, 1'b1);
    inhibit = 1'b1;
    npulse = 0;
    run(100, 1'b1, 1'b1);
    check_int(npulse, 0, "R10");

    // R11: release restarts fresh, including the /2 phase
    cur_req = "R11";
    inhibit = 1'b0;
    step(1'b1, 1'b1);
    npulse = 0;
    run(7, 1'b0, 1'b1);
    check_int(npulse, 0, "R11");
    run(1, 1'b0, 1'b1);
    check_int(npulse, 1, "R11");
    sel_high = 1'b1; div_word = 16'd272;
    restart();
    run(1, 1'b1, 1'b0);
    restart();
    run(543, 1'b1, 1'b0);
    check_int(npulse, 0, "R11");
    run(1, 1'b1, 1'b0);
    check_int(npulse, 1, "R11");

    // random segments, all requirements against the model
    cur_req = "R9";
    for (int s = 0; s < 60; s++) begin
      int len;
      int dens;
      sel_high = ($urandom % 3) == 0;
      sel_full = $urandom % 2;
      if (sel_high || sel_full) div_word = 16'(250 + $urandom % 70);
      else div_word = 16'($urandom % 256);
      len = 500 + int'($urandom % 600);
      dens = 1 + int'($urandom % 4);
      for (int i = 0; i < len; i++) begin
        inhibit = ($urandom % 300) == 0;
        if (($urandom % 400) == 0) div_word = 16'($urandom % 320);
        step(($urandom % 4) < dens, ($urandom % 4) < dens);
      end
      inhibit = 1'b0;
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycle=%0d expected completion", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule